// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects up to eight interrupt request lines, keeps track of which are pending, which are masked and which are currently being serviced, and raises a single interrupt output toward a processor whenever a request deserves attention. A processor configures and steers it through a small byte-wide register port with one address line. First comes a short initialization word sequence. After that come operation words that load the mask, end interrupts, rotate priority, switch special mask mode and choose which status register a read returns.

When the processor acknowledges the interrupt, the controller picks the winning input, marks it in service, and returns a vector byte on the cycle after the acknowledge. Priority is fixed after reset and initialization, with input 0 highest. The lowest-priority input can be moved so that the order rotates. The cascade configuration word is stored and exposed, but no cascade bus exists. The vector output is a one-cycle valid pulse with no ready: the consumer must take the byte in the cycle `vec_valid` is high, and no back-pressure is possible.

Top module: `prio_intc`

## Requirements
- R1: An even-address write with data bit 4 set starts initialization. The next odd write sets the vector base from bits 7:3. A third odd write (stored on `cascade_cfg`) is taken only when first-word bit 1 is 0. A fourth odd write is taken only when first-word bit 0 is 1. After the sequence, odd writes load the mask, and odd reads return the mask.
- R2: A first initialization word clears mask, in-service and edge-latched request bits. It restores fixed priority (input 0 highest), turns off special mask mode, selects the request register for even reads, and clears the fourth-word settings.
- R3: `vec_valid` is high for exactly the cycle after `ack`. With fourth-word bit 0 set, `vec_data` is the base (bits 7:3) with the input number in bits 2:0. Otherwise the upper five bits are zero.
- R4: A mask bit of 1 keeps its input from raising `int_out` or winning an acknowledge. A latched request becomes visible as soon as it is unmasked.
- R5: `int_out` is high only when an unmasked, not-in-service request ranks above every in-service bit.
- R6: Acknowledging sets the winner's in-service bit and, in edge mode, clears its request bit. An acknowledge with no qualifying request returns level 7 and changes no state.
- R7: First-word bit 3 = 0 latches a request on a rising input edge. A request stays latched until it is acknowledged, even if the input stays high. Bit 3 = 1 makes the request register follow the input level with one cycle of delay.
- R8: An even write of 0x20 clears the highest-priority in-service bit. 0x60|L clears in-service bit L.
- R9: An even write of 0xC0|L makes input L lowest and L+1 (mod 8) highest. 0xA0 clears the highest-priority in-service bit and makes that level lowest.
- R10: With fourth-word bit 1 set (automatic end of interrupt), an acknowledge leaves the in-service register unchanged.
- R11: An even write with bits 4:3 = 01 and bit 1 set selects even reads: bit 0 = 1 returns in-service, bit 0 = 0 returns request. With bit 1 clear, the selection is kept.
- R12: Even write 0x68 enters special mask mode and 0x48 leaves it. In that mode any unmasked request not in service raises `int_out`, whatever is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_a0 | input | 1 | Register address line (0 even, 1 odd) |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data selected by `reg_a0` and the read select |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt to the processor |
| ack | input | 1 | Acknowledge strobe, one cycle |
| vec_valid | output | 1 | Vector byte valid (no ready) |
| vec_data | output | 8 | Vector byte |
| cascade_cfg | output | 8 | Stored cascade configuration word |

## Verification
A wrong in-service register shows up as a wrong `int_out` after the next request edge. It also shows up as a wrong vector on the next acknowledge, or directly on an even read once in-service is selected. These are all visible within one or two cycles of the stimulus. A wrong rotation pointer surfaces in the order of vectors across a burst of eight simultaneous requests. A stuck initialization state shows up when the mask is read back or when the vector base comes out wrong.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_W2    = 2'd1,
    ST_W3    = 2'd2,
    ST_W4    = 2'd3
  } init_st_t;
endpackage

// File: rtl/intc_req.sv
module intc_req #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level,
  input  logic         clr_all,
  input  logic [N-1:0] irq,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= irq;
      if (level) irr <= irq;
      else       irr <= (irr & ~ack_clr & {N{~clr_all}}) | (irq & ~prev);
    end
  end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] lowest,
  output logic          found,
  output logic [LW-1:0] idx,
  output logic [LW-1:0] rank
);
  logic [LW-1:0] pos;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    pos   = '0;
    for (int k = 0; k < N; k++) begin
      pos = lowest + LW'(1) + LW'(k);
      if (!found && vec[pos]) begin
        found = 1'b1;
        idx   = pos;
        rank  = LW'(k);
      end
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a0,
  input  logic          wr,
  input  logic [7:0]    d,
  input  logic          ack,
  input  logic          win_found,
  input  logic [LW-1:0] win_idx,
  input  logic          top_found,
  input  logic [LW-1:0] top_idx,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  isr,
  output logic [LW-1:0] lowest,
  output logic          smm,
  output logic          rd_isr,
  output logic          level,
  output logic          cpu_mode,
  output logic          aeoi,
  output logic [7-LW:0] base,
  output logic [7:0]    casc,
  output logic          icw1_hit,
  output logic          vec_valid,
  output logic [7:0]    vec_data
);
  import intc_pkg::*;

  init_st_t      st;
  logic          need4, single;
  logic          is_ocw2, is_ocw3, odd_wr, eoi_hit;
  logic [LW-1:0] lvl;
  logic [LW-1:0] vec_lvl;

  assign icw1_hit = wr & ~a0 & d[4];
  assign odd_wr   = wr & a0;
  assign is_ocw2  = wr & ~a0 & ~d[4] & ~d[3] & (st == ST_READY);
  assign is_ocw3  = wr & ~a0 & ~d[4] &  d[3] & (st == ST_READY);
  assign lvl      = d[6] ? d[LW-1:0] : top_idx;
  assign eoi_hit  = d[6] | top_found;
  assign vec_lvl  = win_found ? win_idx : LW'(N-1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_READY; need4 <= 1'b0; single <= 1'b1; level <= 1'b0;
      base <= '0; casc <= '0; cpu_mode <= 1'b0; aeoi <= 1'b0;
      mask <= '0; isr <= '0; lowest <= LW'(N-1); smm <= 1'b0;
      rd_isr <= 1'b0; vec_valid <= 1'b0; vec_data <= '0;
    end else begin
      vec_valid <= 1'b0;
      if (icw1_hit) begin
        st <= ST_W2; need4 <= d[0]; single <= d[1]; level <= d[3];
        mask <= '0; isr <= '0; lowest <= LW'(N-1); smm <= 1'b0;
        rd_isr <= 1'b0; cpu_mode <= 1'b0; aeoi <= 1'b0;
      end else if (odd_wr) begin
        case (st)
          ST_W2: begin
            base <= d[7:LW];
            st   <= !single ? ST_W3 : (need4 ? ST_W4 : ST_READY);
          end
          ST_W3: begin
            casc <= d;
            st   <= need4 ? ST_W4 : ST_READY;
          end
          ST_W4: begin
            cpu_mode <= d[0];
            aeoi     <= d[1];
            st       <= ST_READY;
          end
          default: mask <= d;
        endcase
      end else if (is_ocw2) begin
        if (d[5] && eoi_hit) isr[lvl] <= 1'b0;
        if (d[7] && eoi_hit && (d[5] || d[6])) lowest <= lvl;
      end else if (is_ocw3) begin
        if (d[1]) rd_isr <= d[0];
        if (d[6]) smm <= d[5];
      end
      if (ack) begin
        vec_valid <= 1'b1;
        vec_data  <= cpu_mode ? {base, vec_lvl} : {{(8-LW){1'b0}}, vec_lvl};
        if (win_found && !aeoi) isr[win_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_a0,
  input  logic         reg_wr,
  input  logic [7:0]   reg_wdata,
  output logic [7:0]   reg_rdata,
  input  logic [N-1:0] irq_in,
  output logic         int_out,
  input  logic         ack,
  output logic         vec_valid,
  output logic [7:0]   vec_data,
  output logic [7:0]   cascade_cfg
);
  logic [N-1:0]  mask, isr, irr, pending, ack_clr;
  logic [LW-1:0] lowest, p_idx, p_rank, i_idx, i_rank;
  logic          p_found, i_found, smm, rd_isr, level, cpu_mode, aeoi, icw1_hit;
  logic [7-LW:0] base;

  assign pending = irr & ~mask & ~isr;
  assign int_out = p_found & (smm | ~i_found | (p_rank < i_rank));
  assign ack_clr = (ack & int_out & ~level) ? (N'(1) << p_idx) : '0;
  assign reg_rdata = reg_a0 ? 8'(mask) : (rd_isr ? 8'(isr) : 8'(irr));

  intc_req #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .level(level), .clr_all(icw1_hit),
    .irq(irq_in), .ack_clr(ack_clr), .irr(irr)
  );

  intc_pick #(.N(N), .LW(LW)) u_pick_req (
    .vec(pending), .lowest(lowest), .found(p_found), .idx(p_idx), .rank(p_rank)
  );

  intc_pick #(.N(N), .LW(LW)) u_pick_isr (
    .vec(isr), .lowest(lowest), .found(i_found), .idx(i_idx), .rank(i_rank)
  );

  intc_regs #(.N(N), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .a0(reg_a0), .wr(reg_wr), .d(reg_wdata),
    .ack(ack), .win_found(int_out), .win_idx(p_idx),
    .top_found(i_found), .top_idx(i_idx),
    .mask(mask), .isr(isr), .lowest(lowest), .smm(smm), .rd_isr(rd_isr),
    .level(level), .cpu_mode(cpu_mode), .aeoi(aeoi), .base(base),
    .casc(cascade_cfg), .icw1_hit(icw1_hit),
    .vec_valid(vec_valid), .vec_data(vec_data)
  );
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          ack,
  input logic          int_out,
  input logic          vec_valid,
  input logic [7:0]    vec_data,
  input logic [N-1:0]  irq_in,
  input logic [N-1:0]  irr,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  isr,
  input logic          level,
  input logic          aeoi,
  input logic          cpu_mode,
  input logic [7-LW:0] base
);
  p_unmasked_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != '0));

  p_vec_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  p_vec_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !ack) |=> !vec_valid);

  p_vec_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && cpu_mode) |-> (vec_data[7:LW] == base));

  p_auto_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi && !reg_wr) |=> $stable(isr));

  p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level |=> (irr == $past(irq_in)));
endmodule

bind prio_intc prio_intc_chk #(.N(N), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .ack(ack), .int_out(int_out),
  .vec_valid(vec_valid), .vec_data(vec_data), .irq_in(irq_in), .irr(irr),
  .mask(mask), .isr(isr), .level(level), .aeoi(aeoi), .cpu_mode(cpu_mode),
  .base(base)
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_a0 = 1'b0, reg_wr = 1'b0, ack = 1'b0;
  logic [7:0] reg_wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] reg_rdata, vec_data, cascade_cfg;
  logic       int_out, vec_valid;
  int         n_run = 0, n_fail = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .reg_a0(reg_a0), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .int_out(int_out), .ack(ack), .vec_valid(vec_valid),
    .vec_data(vec_data), .cascade_cfg(cascade_cfg)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_a0 = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] r);
    @(negedge clk); reg_a0 = a; #1; r = reg_rdata;
  endtask

  task automatic setirq(input logic [7:0] x);
    @(negedge clk); irq_in = x;
    @(negedge clk);
  endtask

  task automatic do_ack(output logic [7:0] r);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R3 vec_valid", {7'd0, vec_valid}, 8'h01);
    r = vec_data;
    @(negedge clk);
    chk("R3 vec_valid drop", {7'd0, vec_valid}, 8'h00);
  endtask

  task automatic rd_isr_chk(input string tag, input logic [7:0] exp);
    logic [7:0] r;
    wr(1'b0, 8'h0B); rd(1'b0, r); chk(tag, r, exp);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk("R2 reset int_out", {7'd0, int_out}, 8'h00);
    rd(1'b1, v); chk("R2 reset mask", v, 8'h00);
    rd(1'b0, v); chk("R2 reset irr", v, 8'h00);

    // R1: edge, single, fourth word, 16/32-bit mode, base 0x40
    wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h01);
    wr(1'b1, 8'h00); rd(1'b1, v); chk("R1 mask readback", v, 8'h00);

    // R3 R5 R6 R8: one input at a time
    for (int i = 0; i < 8; i++) begin
      setirq(8'(1 << i));
      chk("R5 int_out single", {7'd0, int_out}, 8'h01);
      do_ack(v); chk("R3 vector", v, 8'(8'h40 + i));
      rd_isr_chk("R6 isr set", 8'(1 << i));
      wr(1'b0, 8'h0A); rd(1'b0, v); chk("R7 edge latch cleared", v, 8'h00);
      chk("R6 int_out after ack", {7'd0, int_out}, 8'h00);
      wr(1'b0, 8'h20);
      rd_isr_chk("R8 ns eoi", 8'h00);
      setirq(8'h00);
    end

    // R4: masked request held then released
    for (int m = 0; m < 8; m++) begin
      wr(1'b1, 8'(1 << m));
      setirq(8'(1 << m));
      chk("R4 masked int_out", {7'd0, int_out}, 8'h00);
      rd(1'b1, v); chk("R4 mask read", v, 8'(1 << m));
      wr(1'b1, 8'h00);
      chk("R4 unmasked int_out", {7'd0, int_out}, 8'h01);
      do_ack(v); chk("R4 vector", v, 8'(8'h40 + m));
      wr(1'b0, 8'h20);
      setirq(8'h00);
    end

    // R9: set-priority sweep
    for (int l = 0; l < 8; l++) begin
      wr(1'b0, 8'(8'hC0 | l));
      setirq(8'hFF);
      for (int k = 0; k < 8; k++) begin
        do_ack(v); chk("R9 rotated order", v, 8'(8'h40 + ((l + 1 + k) % 8)));
        wr(1'b0, 8'h20);
      end
      setirq(8'h00);
    end
    wr(1'b0, 8'hC7);

    // R9: rotate on non-specific EOI
    setirq(8'h0A);
    do_ack(v); chk("R9 pre-rotate", v, 8'h41);
    wr(1'b0, 8'hA0);
    setirq(8'h0B);
    do_ack(v); chk("R9 after rotate eoi", v, 8'h43);
    wr(1'b0, 8'h20);
    do_ack(v); chk("R9 wrapped", v, 8'h40);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'hC7);
    setirq(8'h00);

    // R5 R8: nesting
    setirq(8'h20);
    do_ack(v); chk("R5 nest first", v, 8'h45);
    setirq(8'h24);
    chk("R5 higher preempts", {7'd0, int_out}, 8'h01);
    setirq(8'h64);
    do_ack(v); chk("R5 nest second", v, 8'h42);
    rd_isr_chk("R5 nested isr", 8'h24);
    wr(1'b0, 8'h20);
    rd_isr_chk("R8 ns eoi nested", 8'h20);
    chk("R5 lower blocked", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h65);
    chk("R8 specific eoi", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R5 lower served", v, 8'h46);
    wr(1'b0, 8'h20);
    setirq(8'h00);

    // R12: special mask mode
    setirq(8'h20);
    do_ack(v);
    setirq(8'h60);
    chk("R12 normal blocks", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h68);
    chk("R12 smm allows", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R12 smm vector", v, 8'h46);
    rd_isr_chk("R12 smm isr", 8'h60);
    wr(1'b0, 8'h48); wr(1'b0, 8'h20); wr(1'b0, 8'h20);
    rd_isr_chk("R12 cleanup", 8'h00);
    setirq(8'h00);

    // R6: spurious acknowledge
    chk("R6 idle", {7'd0, int_out}, 8'h00);
    do_ack(v); chk("R6 spurious vector", v, 8'h47);
    rd_isr_chk("R6 spurious no isr", 8'h00);

    // R11: read select kept when bit 1 clear
    setirq(8'h01);
    wr(1'b0, 8'h0B); wr(1'b0, 8'h08);
    rd(1'b0, v); chk("R11 select kept", v, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R11 irr select", v, 8'h01);
    do_ack(v); wr(1'b0, 8'h20);
    setirq(8'h00);

    // R1 R10: cascaded init with third and fourth words, auto EOI
    wr(1'b0, 8'h11); wr(1'b1, 8'h80); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    chk("R1 cascade word", cascade_cfg, 8'h04);
    wr(1'b1, 8'h5A); rd(1'b1, v); chk("R1 mask after seq", v, 8'h5A);
    wr(1'b1, 8'h00);
    setirq(8'h08);
    do_ack(v); chk("R3 new base", v, 8'h83);
    rd_isr_chk("R10 auto eoi", 8'h00);
    chk("R10 int_out low", {7'd0, int_out}, 8'h00);
    setirq(8'h00);

    // R2 R7: level mode, no fourth word
    wr(1'b1, 8'hF0);
    wr(1'b0, 8'h1A); wr(1'b1, 8'h60);
    rd(1'b1, v); chk("R2 mask cleared", v, 8'h00);
    setirq(8'h10);
    rd(1'b0, v); chk("R2 read sel irr", v, 8'h10);
    chk("R7 level int", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R3 8-bit vector", v, 8'h04);
    chk("R7 in service blocks", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R7 level held", v, 8'h10);
    setirq(8'h00);
    rd(1'b0, v); chk("R7 level drop", v, 8'h00);
    wr(1'b0, 8'h20);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule